// File: doc/BRIEF.md
# Auto-Stepping Data ROM Access Port

A host CPU uses this block to read a large data ROM through a byte-wide register window. It holds a 24-bit pointer, a 16-bit adjust value and a 16-bit step value. A read from either of two data ports fetches one ROM byte and can then move the pointer or the adjust value. The mode byte selects how each register moves and whether its arithmetic is signed. The host loads the pointer once, then streams bytes, gathers strided data or does offset lookups without rewriting the address between reads.

Every address the block computes is reduced modulo the ROM size parameter. A fixed base offset is added only to the address driven to the ROM. The ROM answers one cycle after it sees an address. A small sequencer presents the address, waits for the byte, returns it with a one-cycle valid pulse, and only then commits any register update. The block ignores host accesses while that sequence is in flight.

The pointer is wrapped with a single subtract. The size parameter must therefore be at least 2^23 and no more than 2^24, and base offset plus size must fit in the address width.

Top module: `rom_stream_port`

## Requirements
- R1: The primary data port (offset 8) returns 0x00 one clock after the strobe and starts no ROM access unless all three pointer bytes have been written since reset. The pointer bytes are offsets 0, 1 and 2, low to high, and each write sets its bit 0, 1 or 2 of a written mask.
- R2: The secondary data port (offset 9) returns 0x00 one clock after the strobe unless all five setup bytes have been written. Those are the pointer bytes plus adjust low (offset 3, mask bit 3) and adjust high (offset 4, mask bit 4).
- R3: A write to the mode byte (offset 7) is ignored until both adjust bytes have been written. An accepted mode write also clears the two immediate-adjust tracking bits.
- R4: A primary read with mode bit 1 clear and mode bit 0 clear reads the byte at the pointer, then adds one to the pointer.
- R5: With mode bit 1 clear and mode bit 0 set, the pointer moves by the step register (offsets 5 low and 6 high). Mode bit 2 set makes the step signed, mode bit 2 clear makes it unsigned.
- R6: With mode bit 1 clear and mode bit 4 set, the step is added to the 16-bit adjust register, which wraps modulo 2^16, and the pointer is left unchanged.
- R7: A primary read with mode bit 1 set reads at pointer plus adjust, then adds one to adjust, wrapping 0xFFFF to 0x0000. Mode bit 3 set makes adjust signed in the address sum.
- R8: Every effective address and every new pointer value is taken modulo ROM_SIZE, including negative sums and pointer values written above the size. The ROM address output equals BASE_OFFSET plus the effective address.
- R9: The secondary port reads at pointer plus adjust, with adjust signed when mode bit 3 is set. With mode bits 5 and 6 both set, the pointer then becomes that address (bit 4 clear), or adjust is doubled (bit 4 set). Otherwise nothing changes.
- R10: With mode bit 1 set and exactly one of bits 5 or 6 set, a write to adjust low or high marks its tracking bit. Once both bits are marked and bit 4 is clear, each such write adds the new adjust value to the pointer at once. Bit 5 adds the sign- or zero-extended low byte, bit 6 adds the full 16-bit value, and bit 3 sets the signedness.
- R11: `rd_valid` is a single-cycle pulse. It comes one clock after a register read or a gated port read, and three clocks after a port read that reaches the ROM. Reads and writes that arrive during a ROM read are ignored.
- R12: Reset clears all registers and the written mask, drops `rd_valid`, and parks the ROM address at BASE_OFFSET.
- R13: Offsets 0 to 7 read back the stored register value with no side effect. Offsets 10 to 15 read as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| reg_sel | input | 4 | Register offset |
| wr_data | input | 8 | Host write byte |
| rd_data | output | 8 | Host read byte |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` |
| rom_addr | output | AW | Address presented to the ROM |
| rom_data | input | 8 | ROM byte, valid the cycle after the address |

## Verification
The bench goes after four groups of corner cases.
- Gating of both ports and of the mode byte. A design that ignored the written mask would fetch garbage or accept a mode before the setup is complete.
- Wrap cases: stepping off the last ROM byte, a negative signed adjust from pointer zero, and a pointer written above the size. A wrong modulo shows up as an address outside the ROM window or a wrong byte.
- Adjust arithmetic: the 0xFFFF-to-zero wrap and the choice between the 8-bit and 16-bit signed immediate adds. A slip in sign extension lands the pointer off by 0x100 or more.
- Timing: a held strobe and a write during a ROM fetch. A design without a busy gate would double-step the pointer or corrupt the step register.

// File: rtl/rom_stream_port.sv
module rom_stream_port #(
  parameter int AW = 24,
  parameter logic [AW-1:0] ROM_SIZE = 'hE00000,
  parameter logic [AW-1:0] BASE_OFFSET = 'h100000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [3:0]    reg_sel,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data,
  output logic          rd_valid,
  output logic [AW-1:0] rom_addr,
  input  logic [7:0]    rom_data
);
  localparam logic signed [AW+1:0] SZS = (AW+2)'(ROM_SIZE);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA} st_t;

  st_t          st_q;
  logic         sec_q;
  logic [AW-1:0] ptr_q;
  logic [15:0]  adj_q, step_q;
  logic [7:0]   mode_q;
  logic [4:0]   written_q;
  logic [1:0]   imm_q;

  function automatic logic signed [17:0] ext16(input logic [15:0] v, input logic sg);
    return {sg & v[15], sg & v[15], v};
  endfunction

  function automatic logic signed [17:0] ext8(input logic [7:0] v, input logic sg);
    return {{10{sg & v[7]}}, v};
  endfunction

  function automatic logic [AW-1:0] wrap_add(input logic [AW-1:0] b, input logic signed [17:0] d);
    logic signed [AW+1:0] s;
    s = $signed({2'b00, b}) + $signed({{(AW-16){d[17]}}, d});
    if (s < 0) s = s + SZS;
    else if (s >= SZS) s = s - SZS;
    return s[AW-1:0];
  endfunction

  wire busy = (st_q != S_IDLE);
  wire [AW-1:0] ptr_n = (ptr_q >= ROM_SIZE) ? ptr_q - ROM_SIZE : ptr_q;
  wire signed [17:0] adj_d  = ext16(adj_q, mode_q[3]);
  wire signed [17:0] step_d = mode_q[0] ? ext16(step_q, mode_q[2]) : 18'sd1;
  wire [AW-1:0] sum_addr = wrap_add(ptr_n, adj_d);
  wire [AW-1:0] pri_addr = mode_q[1] ? sum_addr : ptr_n;

  wire        adj_wr = wr_en && !busy && (reg_sel == 4'd3 || reg_sel == 4'd4);
  wire [15:0] adj_w  = (reg_sel == 4'd3) ? {adj_q[15:8], wr_data} : {wr_data, adj_q[7:0]};
  wire [1:0]  imm_w  = imm_q | ((reg_sel == 4'd3) ? 2'b01 : 2'b10);
  wire        imm_on = mode_q[1] && (mode_q[5] ^ mode_q[6]);
  wire signed [17:0] imm_d = mode_q[5] ? ext8(adj_w[7:0], mode_q[3]) : ext16(adj_w, mode_q[3]);

  assign rom_addr = rom_addr_q;
  logic [AW-1:0] rom_addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      sec_q <= 1'b0;
      ptr_q <= '0;
      adj_q <= '0;
      step_q <= '0;
      mode_q <= '0;
      written_q <= '0;
      imm_q <= '0;
      rd_data <= '0;
      rd_valid <= 1'b0;
      rom_addr_q <= BASE_OFFSET;
    end else begin
      rd_valid <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (wr_en) begin
            case (reg_sel)
              4'd0: begin ptr_q[7:0]   <= wr_data; written_q[0] <= 1'b1; end
              4'd1: begin ptr_q[15:8]  <= wr_data; written_q[1] <= 1'b1; end
              4'd2: begin ptr_q[23:16] <= wr_data; written_q[2] <= 1'b1; end
              4'd3: written_q[3] <= 1'b1;
              4'd4: written_q[4] <= 1'b1;
              4'd5: step_q[7:0]  <= wr_data;
              4'd6: step_q[15:8] <= wr_data;
              4'd7: if (written_q[4:3] == 2'b11) begin
                mode_q <= wr_data;
                imm_q <= '0;
              end
              default: ;
            endcase
            if (adj_wr) begin
              adj_q <= adj_w;
              if (imm_on) begin
                imm_q <= imm_w;
                if (imm_w == 2'b11 && !mode_q[4]) ptr_q <= wrap_add(ptr_n, imm_d);
              end
            end
          end else if (rd_en) begin
            rd_valid <= 1'b1;
            rd_data <= 8'h00;
            case (reg_sel)
              4'd0: rd_data <= ptr_q[7:0];
              4'd1: rd_data <= ptr_q[15:8];
              4'd2: rd_data <= ptr_q[23:16];
              4'd3: rd_data <= adj_q[7:0];
              4'd4: rd_data <= adj_q[15:8];
              4'd5: rd_data <= step_q[7:0];
              4'd6: rd_data <= step_q[15:8];
              4'd7: rd_data <= mode_q;
              4'd8: if (written_q[2:0] == 3'b111) begin
                rd_valid <= 1'b0;
                sec_q <= 1'b0;
                rom_addr_q <= BASE_OFFSET + pri_addr;
                st_q <= S_ADDR;
              end
              4'd9: if (written_q == 5'h1F) begin
                rd_valid <= 1'b0;
                sec_q <= 1'b1;
                rom_addr_q <= BASE_OFFSET + sum_addr;
                st_q <= S_ADDR;
              end
              default: ;
            endcase
          end
        end
        S_ADDR: st_q <= S_DATA;
        default: begin
          st_q <= S_IDLE;
          rd_data <= rom_data;
          rd_valid <= 1'b1;
          if (!sec_q) begin
            if (mode_q[1]) adj_q <= adj_q + 16'd1;
            else if (mode_q[4]) adj_q <= adj_q + step_d[15:0];
            else ptr_q <= wrap_add(ptr_n, step_d);
          end else if (mode_q[5] && mode_q[6]) begin
            if (mode_q[4]) adj_q <= {adj_q[14:0], 1'b0};
            else ptr_q <= sum_addr;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/rom_stream_port_chk.sv
module rom_stream_port_chk #(
  parameter int AW = 24,
  parameter logic [AW-1:0] ROM_SIZE = 'hE00000,
  parameter logic [AW-1:0] BASE_OFFSET = 'h100000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [3:0]    reg_sel,
  input logic [7:0]    rd_data,
  input logic          rd_valid,
  input logic [AW-1:0] rom_addr,
  input logic          busy,
  input logic [4:0]    written,
  input logic [7:0]    mode
);
  localparam logic [AW:0] LO = {1'b0, BASE_OFFSET};
  localparam logic [AW:0] HI = {1'b0, BASE_OFFSET} + {1'b0, ROM_SIZE};

  assert_gate_primary_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_en && rd_en && reg_sel == 4'd8 && written[2:0] != 3'b111)
      |=> (rd_valid && rd_data == 8'h00 && $stable(rom_addr)));

  assert_gate_secondary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_en && rd_en && reg_sel == 4'd9 && written != 5'h1F)
      |=> (rd_valid && rd_data == 8'h00));

  assert_mode_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && reg_sel == 4'd7 && written[4:3] != 2'b11) |=> $stable(mode));

  assert_rom_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, rom_addr} >= LO) && ({1'b0, rom_addr} < HI));

  assert_rom_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_en && rd_en && reg_sel == 4'd8 && written[2:0] == 3'b111)
      |=> !rd_valid ##1 !rd_valid ##1 rd_valid);

  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_reset_state_R12: assert property (@(posedge clk)
    !rst_n |=> (written == 5'd0 && mode == 8'd0 && !rd_valid && rom_addr == BASE_OFFSET));
endmodule

bind rom_stream_port rom_stream_port_chk #(.AW(AW), .ROM_SIZE(ROM_SIZE), .BASE_OFFSET(BASE_OFFSET)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
  .rd_data(rd_data), .rd_valid(rd_valid), .rom_addr(rom_addr), .busy(busy),
  .written(written_q), .mode(mode_q)
);

// File: tb/rom_stream_port_tb.sv
module rom_stream_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] SIZE = 24'hE00000;
  localparam logic [23:0] BASE = 24'h100000;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] reg_sel = '0;
  logic [7:0] wr_data = '0, rd_data, rom_data;
  logic rd_valid;
  logic [23:0] rom_addr;
  int checks = 0, fails = 0, pulses = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] romf(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  always_ff @(posedge clk) rom_data <= romf(rom_addr);
  always @(posedge clk) if (rd_valid) pulses <= pulses + 1;

  rom_stream_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .rom_addr(rom_addr), .rom_data(rom_data)
  );

  // op: 0 write, 1 ROM read (exp = effective address), 2 byte read
  localparam int NV = 61;
  localparam logic [41:0] VEC [NV] = '{
    {2'd2, 4'd1, 4'd8, 8'h00, 24'h00},     // R1 nothing written
    {2'd0, 4'd1, 4'd0, 8'h10, 24'h00},
    {2'd0, 4'd1, 4'd1, 8'h20, 24'h00},
    {2'd2, 4'd1, 4'd8, 8'h00, 24'h00},     // R1 two of three
    {2'd0, 4'd3, 4'd2, 8'h00, 24'h00},
    {2'd0, 4'd3, 4'd7, 8'h01, 24'h00},
    {2'd2, 4'd3, 4'd7, 8'h00, 24'h00},     // R3 mode locked
    {2'd1, 4'd4, 4'd8, 8'h00, 24'h002010}, // R4
    {2'd2, 4'd4, 4'd0, 8'h00, 24'h11},
    {2'd2, 4'd2, 4'd9, 8'h00, 24'h00},     // R2
    {2'd0, 4'd3, 4'd3, 8'h05, 24'h00},
    {2'd0, 4'd3, 4'd4, 8'h00, 24'h00},
    {2'd0, 4'd5, 4'd5, 8'h00, 24'h00},
    {2'd0, 4'd5, 4'd6, 8'h01, 24'h00},
    {2'd0, 4'd3, 4'd7, 8'h01, 24'h00},
    {2'd2, 4'd3, 4'd7, 8'h00, 24'h01},     // R3 accepted
    {2'd1, 4'd5, 4'd8, 8'h00, 24'h002011}, // R5 unsigned step
    {2'd2, 4'd5, 4'd1, 8'h00, 24'h21},
    {2'd0, 4'd5, 4'd5, 8'hFE, 24'h00},
    {2'd0, 4'd5, 4'd6, 8'hFF, 24'h00},
    {2'd0, 4'd5, 4'd7, 8'h05, 24'h00},
    {2'd1, 4'd5, 4'd8, 8'h00, 24'h002111}, // R5 signed step
    {2'd2, 4'd5, 4'd0, 8'h00, 24'h0F},
    {2'd0, 4'd5, 4'd7, 8'h01, 24'h00},
    {2'd1, 4'd5, 4'd8, 8'h00, 24'h00210F},
    {2'd2, 4'd5, 4'd2, 8'h00, 24'h01},
    {2'd0, 4'd6, 4'd7, 8'h11, 24'h00},
    {2'd1, 4'd6, 4'd8, 8'h00, 24'h01210D}, // R6
    {2'd2, 4'd6, 4'd3, 8'h00, 24'h03},
    {2'd2, 4'd6, 4'd0, 8'h00, 24'h0D},
    {2'd0, 4'd7, 4'd7, 8'h02, 24'h00},
    {2'd1, 4'd7, 4'd8, 8'h00, 24'h012110}, // R7
    {2'd2, 4'd7, 4'd3, 8'h00, 24'h04},
    {2'd0, 4'd7, 4'd3, 8'hFF, 24'h00},
    {2'd0, 4'd7, 4'd4, 8'hFF, 24'h00},
    {2'd1, 4'd7, 4'd8, 8'h00, 24'h02210C}, // R7 unsigned, adjust wraps
    {2'd2, 4'd7, 4'd3, 8'h00, 24'h00},
    {2'd2, 4'd7, 4'd4, 8'h00, 24'h00},
    {2'd0, 4'd7, 4'd3, 8'hFF, 24'h00},
    {2'd0, 4'd7, 4'd4, 8'hFF, 24'h00},
    {2'd0, 4'd7, 4'd7, 8'h0A, 24'h00},
    {2'd1, 4'd7, 4'd8, 8'h00, 24'h01210C}, // R7 signed
    {2'd2, 4'd7, 4'd3, 8'h00, 24'h00},
    {2'd0, 4'd8, 4'd0, 8'hFF, 24'h00},
    {2'd0, 4'd8, 4'd1, 8'hFF, 24'h00},
    {2'd0, 4'd8, 4'd2, 8'hDF, 24'h00},
    {2'd0, 4'd8, 4'd7, 8'h00, 24'h00},
    {2'd1, 4'd8, 4'd8, 8'h00, 24'hDFFFFF}, // R8 last byte, step wraps
    {2'd2, 4'd8, 4'd2, 8'h00, 24'h00},
    {2'd2, 4'd8, 4'd0, 8'h00, 24'h00},
    {2'd0, 4'd8, 4'd3, 8'hFE, 24'h00},
    {2'd0, 4'd8, 4'd4, 8'hFF, 24'h00},
    {2'd0, 4'd8, 4'd7, 8'h0A, 24'h00},
    {2'd1, 4'd8, 4'd8, 8'h00, 24'hDFFFFE}, // R8 negative sum
    {2'd2, 4'd8, 4'd3, 8'h00, 24'hFF},
    {2'd0, 4'd8, 4'd0, 8'hFF, 24'h00},
    {2'd0, 4'd8, 4'd1, 8'hFF, 24'h00},
    {2'd0, 4'd8, 4'd2, 8'hFF, 24'h00},
    {2'd0, 4'd8, 4'd7, 8'h00, 24'h00},
    {2'd1, 4'd8, 4'd8, 8'h00, 24'h1FFFFF}, // R8 pointer above size
    {2'd2, 4'd8, 4'd2, 8'h00, 24'h20}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; reg_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] s, output logic [7:0] d, output logic [23:0] a, output int lat);
    @(negedge clk); rd_en = 1'b1; reg_sel = s;
    @(negedge clk); rd_en = 1'b0; lat = 1;
    while (!rd_valid && lat < 8) begin @(negedge clk); lat++; end
    d = rd_data; a = rom_addr;
  endtask

  task automatic rd_byte(input logic [3:0] s, input logic [7:0] e, input string tag);
    logic [7:0] d; logic [23:0] a; int l;
    rd(s, d, a, l);
    chk(d == e && l < 8, tag, {24'd0, d}, {24'd0, e});
  endtask

  task automatic rd_rom(input logic [3:0] s, input logic [23:0] eff, input string tag);
    logic [7:0] d; logic [23:0] a; int l;
    rd(s, d, a, l);
    chk(d == romf(BASE + eff) && a == BASE + eff, tag, {a, d}, {BASE + eff, romf(BASE + eff)});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d; logic [23:0] a; int l;
    repeat (3) @(negedge clk);
    chk(!rd_valid && rom_addr == BASE, "R12 reset outputs", {7'd0, rd_valid, rom_addr}, {8'd0, BASE});
    rst_n = 1'b1;
    for (int k = 0; k < 8; k++) rd_byte(4'(k), 8'h00, $sformatf("R12 reset register %0d", k));

    for (int i = 0; i < NV; i++) begin
      logic [41:0] v;
      v = VEC[i];
      if (v[41:40] == 2'd0) wr(v[35:32], v[31:24]);
      else if (v[41:40] == 2'd1) rd_rom(v[35:32], v[23:0], $sformatf("R%0d vector %0d", v[39:36], i));
      else rd_byte(v[35:32], v[7:0], $sformatf("R%0d vector %0d", v[39:36], i));
    end

    // R9 secondary port
    wr(4'd0, 8'h00); wr(4'd1, 8'h10); wr(4'd2, 8'h00);
    wr(4'd3, 8'h30); wr(4'd4, 8'h00); wr(4'd7, 8'h00);
    rd_rom(4'd9, 24'h001030, "R9 secondary read, no update");
    rd_byte(4'd0, 8'h00, "R9 pointer untouched");
    wr(4'd7, 8'h60);
    rd_rom(4'd9, 24'h001030, "R9 pointer takes sum");
    rd_byte(4'd0, 8'h30, "R9 pointer updated");
    wr(4'd7, 8'h70);
    rd_rom(4'd9, 24'h001060, "R9 doubling mode read");
    rd_byte(4'd3, 8'h60, "R9 adjust doubled");
    rd_byte(4'd0, 8'h30, "R9 pointer kept when doubling");
    wr(4'd3, 8'hF0); wr(4'd4, 8'hFF); wr(4'd7, 8'h68);
    rd_rom(4'd9, 24'h001020, "R9 signed adjust");
    rd_byte(4'd0, 8'h20, "R9 signed pointer update");

    // R10 immediate adjust
    wr(4'd7, 8'h22);
    wr(4'd3, 8'h80);
    rd_byte(4'd0, 8'h20, "R10 one byte only, no move");
    wr(4'd4, 8'h00);
    rd_byte(4'd0, 8'hA0, "R10 low byte unsigned add");
    rd_byte(4'd1, 8'h10, "R10 low byte unsigned add high");
    wr(4'd7, 8'h2A); wr(4'd3, 8'hF0); wr(4'd4, 8'h12);
    rd_byte(4'd0, 8'h90, "R10 low byte signed add");
    wr(4'd7, 8'h42); wr(4'd3, 8'h00); wr(4'd4, 8'h01);
    rd_byte(4'd1, 8'h11, "R10 full adjust add");
    wr(4'd3, 8'h02);
    rd_byte(4'd0, 8'h92, "R10 retrigger low");
    rd_byte(4'd1, 8'h12, "R10 retrigger high");
    wr(4'd7, 8'h52); wr(4'd3, 8'h00); wr(4'd4, 8'h01);
    rd_byte(4'd1, 8'h12, "R10 suppressed by bit 4");
    wr(4'd7, 8'h62); wr(4'd3, 8'h00); wr(4'd4, 8'h01);
    rd_byte(4'd0, 8'h92, "R10 both bits set, no move");

    // R11 latency, R13 unmapped offsets
    wr(4'd7, 8'h00);
    rd(4'd0, d, a, l);
    chk(l == 1, "R11 register read latency", l, 1);
    rd(4'd8, d, a, l);
    chk(l == 3, "R11 ROM read latency", l, 3);
    rd_byte(4'd12, 8'h00, "R13 unmapped offset");
    rd_byte(4'd0, 8'h93, "R13 readback after step");

    // R11 held strobe and write while busy
    @(negedge clk); pulses = 0; rd_en = 1'b1; reg_sel = 4'd8;
    @(negedge clk);
    @(negedge clk); rd_en = 1'b0; wr_en = 1'b1; reg_sel = 4'd5; wr_data = 8'h77;
    @(negedge clk); wr_en = 1'b0;
    repeat (4) @(negedge clk);
    chk(pulses == 1, "R11 one pulse for held strobe", pulses, 1);
    rd_byte(4'd0, 8'h94, "R11 single advance");
    rd_byte(4'd5, 8'hFE, "R11 write during fetch ignored");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule